// File: doc/BRIEF.md
# Fast/Trickle Charge Mode Controller

This block holds the charge-mode state of a nickel-chemistry battery charger. Every input is a synchronous digital flag produced elsewhere. The flags cover the following conditions:

- the divided battery voltage against its window
- a qualified negative-slope event
- a backup timer expiry
- over- and under-temperature
- a select between timer backup and temperature backup
- supply undervoltage

From these flags the block drives a single mode output that is high for fast charge and low for trickle.

Some trickle causes are sticky. A negative-slope event, a timer expiry and an over-temperature each set their own latch. Other causes release by themselves when they go away: the voltage window, under-temperature and supply undervoltage. The sticky latches are cleared by a one-clock clear pulse. This pulse is also sent to the external timer. It fires when the battery voltage comes back into its window, or when the supply recovers. The latches are also held clear for as long as the supply is low. Both outputs are registered, so each one reflects the inputs sampled at the previous clock edge.

Top module: `chg_mode_ctrl`

## Requirements
- R1: After reset is released, `ft_out` is 1 (fast charge) and `clr_pulse` is 0.
- R2: When `v_above` or `v_below` is 1 at a clock edge, `ft_out` is 0 after that edge. It returns to 1 once both are 0 again, as long as no other cause is present.
- R3: When the window condition changes from outside to inside, `clr_pulse` is 1 for exactly the following cycle. The same edge clears the slope, timer and over-temperature latches, and `ft_out` goes back to 1 if no other cause is present. Inside the window means `v_above`=0 and `v_below`=0.
- R4: A `slope_drop` flag latches trickle. `ft_out` stays 0 after the flag falls, until the next clear.
- R5: When `tmode_timer`=1, `tmr_expired` latches trickle until the next clear. When `tmode_timer`=0, `tmr_expired` has no effect on `ft_out`.
- R6: When `tmode_timer`=0, `temp_over` latches trickle, and trickle holds after `temp_over` falls until the next clear. When `tmode_timer`=1, `temp_over` has no effect.
- R7: When `tmode_timer`=0, `temp_under` forces trickle only while it is 1, and sets no latch. When `tmode_timer`=1, `temp_under` has no effect.
- R8: While `sup_low` is 1, `ft_out` is 0 and all latches are held clear. When `sup_low` falls, `clr_pulse` is 1 for the following cycle.
- R9: If a latch set request arrives at the same edge as a window-entry clear, the clear wins. `ft_out` is then 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| v_above | input | 1 | Battery voltage is above the fast-charge window |
| v_below | input | 1 | Battery voltage is below the fast-charge window |
| slope_drop | input | 1 | Qualified negative-slope event |
| tmr_expired | input | 1 | Backup timer reached its limit |
| temp_over | input | 1 | Pack temperature is above the upper limit |
| temp_under | input | 1 | Pack temperature is below the lower limit |
| tmode_timer | input | 1 | 1 selects timer backup, 0 selects temperature backup |
| sup_low | input | 1 | Supply is below its operating level |
| ft_out | output | 1 | 1 means fast charge, 0 means trickle |
| clr_pulse | output | 1 | One-clock clear sent to the timer and the latches |

## Verification
The hardest states to reach from the ports are the ones where a sticky latch has been set and must be told apart from a self-releasing cause. The output looks the same in both cases during the offending cycle. So every input combination, under both backup modes, is applied for one cycle from a known clean state, and is followed by two clean cycles. The second clean cycle shows whether trickle persisted, and the clear pulse shows whether it lasted exactly one cycle. Before each combination, the latches are emptied through the normal interface: the window is left for one cycle and then re-entered. A directed case lines up a set request with that re-entry edge to observe which one takes priority.

// File: rtl/chg_pkg.sv
package chg_pkg;
  // Sticky trickle causes, one latch each
  localparam int N_STICKY  = 3;
  localparam int IDX_SLOPE = 0;
  localparam int IDX_TMR   = 1;
  localparam int IDX_OT    = 2;

  // Self-recovering good conditions watched for re-entry
  localparam int N_OKCOND  = 2;
  localparam int IDX_WIN   = 0;
  localparam int IDX_SUP   = 1;

  typedef logic [N_STICKY-1:0] sticky_vec_t;
  typedef logic [N_OKCOND-1:0] okcond_vec_t;
endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/chg_edge_det.sv
module chg_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic [W-1:0] cond,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = cond;
    rise   = cond & ~prev_q;
  end

  // Reset to "all good" so that power-up itself never looks like a re-entry
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) prev_q <= '1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/chg_sticky_bank.sv
module chg_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic [N-1:0] set_req,
  input  logic         clr,
  output logic [N-1:0] lat_d
);
  logic [N-1:0] lat_q;

  for (genvar g = 0; g < N; g++) begin : g_cell
    // Clear has priority over set
    always_comb begin
      if (clr)             lat_d[g] = 1'b0;
      else if (set_req[g]) lat_d[g] = 1'b1;
      else                 lat_d[g] = lat_q[g];
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) lat_q[g] <= 1'b0;
      else        lat_q[g] <= lat_d[g];
    end
  end
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
  import chg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic v_above,
  input  logic v_below,
  input  logic slope_drop,
  input  logic tmr_expired,
  input  logic temp_over,
  input  logic temp_under,
  input  logic tmode_timer,
  input  logic sup_low,
  output logic ft_out,
  output logic clr_pulse
);
  logic        rst_s;
  okcond_vec_t ok_vec;
  okcond_vec_t rise_vec;
  sticky_vec_t set_vec;
  sticky_vec_t lat_d;
  logic        clr_any;
  logic        clr_hold;
  logic        soft_block;
  logic        ft_d;
  logic        clr_d;

  chg_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  always_comb begin
    ok_vec          = '0;
    ok_vec[IDX_WIN] = ~(v_above | v_below);
    ok_vec[IDX_SUP] = ~sup_low;
  end

  chg_edge_det #(.W(N_OKCOND)) i_edge (
    .clk   (clk),
    .rst_s (rst_s),
    .cond  (ok_vec),
    .rise  (rise_vec)
  );

  // Backup mode selects which of the timer / temperature flags count
  always_comb begin
    set_vec            = '0;
    set_vec[IDX_SLOPE] = slope_drop;
    set_vec[IDX_TMR]   = tmode_timer & tmr_expired;
    set_vec[IDX_OT]    = ~tmode_timer & temp_over;
    clr_any            = |rise_vec;
    clr_hold           = clr_any | sup_low;
    soft_block         = ~tmode_timer & temp_under;
  end

  chg_sticky_bank #(.N(N_STICKY)) i_sticky (
    .clk     (clk),
    .rst_s   (rst_s),
    .set_req (set_vec),
    .clr     (clr_hold),
    .lat_d   (lat_d)
  );

  always_comb begin
    ft_d  = (&ok_vec) & ~(|lat_d) & ~soft_block;
    clr_d = clr_any;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ft_out    <= 1'b1;
      clr_pulse <= 1'b0;
    end else begin
      ft_out    <= ft_d;
      clr_pulse <= clr_d;
    end
  end
endmodule

// File: rtl/chg_mode_chk.sv
module chg_mode_chk (
  input logic clk,
  input logic rst_s,
  input logic v_above,
  input logic v_below,
  input logic slope_drop,
  input logic tmr_expired,
  input logic temp_over,
  input logic temp_under,
  input logic tmode_timer,
  input logic sup_low,
  input logic ft_out,
  input logic clr_pulse
);
  logic win_ok, sup_ok, win_prev, sup_prev, entry;

  assign win_ok = !v_above && !v_below;
  assign sup_ok = !sup_low;
  assign entry  = (win_ok && !win_prev) || (sup_ok && !sup_prev) || sup_low;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      win_prev <= 1'b1;
      sup_prev <= 1'b1;
    end else begin
      win_prev <= win_ok;
      sup_prev <= sup_ok;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_s) |-> (ft_out && !clr_pulse));

  a_r2_window_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    !win_ok |=> !ft_out);

  a_r3_entry_clear: assert property (@(posedge clk) disable iff (!rst_s)
    (win_ok && !win_prev) |=> clr_pulse);

  a_r4_slope_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    (slope_drop && !entry) |=> !ft_out);

  a_r5_timer_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    (tmode_timer && tmr_expired && !entry) |=> !ft_out);

  a_r6_overtemp_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    (!tmode_timer && temp_over && !entry) |=> !ft_out);

  a_r7_undertemp_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    (!tmode_timer && temp_under) |=> !ft_out);

  a_r8_supply_trickle: assert property (@(posedge clk) disable iff (!rst_s)
    sup_low |=> !ft_out);

  a_r8_supply_clear: assert property (@(posedge clk) disable iff (!rst_s)
    (sup_ok && !sup_prev) |=> clr_pulse);
endmodule

bind chg_mode_ctrl chg_mode_chk i_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .v_above     (v_above),
  .v_below     (v_below),
  .slope_drop  (slope_drop),
  .tmr_expired (tmr_expired),
  .temp_over   (temp_over),
  .temp_under  (temp_under),
  .tmode_timer (tmode_timer),
  .sup_low     (sup_low),
  .ft_out      (ft_out),
  .clr_pulse   (clr_pulse)
);

// File: tb/test_chg_mode_ctrl.sv
`timescale 1ns/1ps
module test_chg_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic v_above, v_below, slope_drop, tmr_expired;
  logic temp_over, temp_under, tmode_timer, sup_low;
  logic ft_out, clr_pulse;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #2.5 clk = ~clk;

  chg_mode_ctrl i_chg_mode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .v_above(v_above), .v_below(v_below), .slope_drop(slope_drop),
    .tmr_expired(tmr_expired), .temp_over(temp_over), .temp_under(temp_under),
    .tmode_timer(tmode_timer), .sup_low(sup_low),
    .ft_out(ft_out), .clr_pulse(clr_pulse)
  );

  // bit0 v_above, bit1 v_below, bit2 slope, bit3 timer, bit4 overtemp, bit5 undertemp, bit6 supply low
  task automatic drive(input logic [6:0] v, input logic tm);
    v_above = v[0]; v_below = v[1]; slope_drop = v[2]; tmr_expired = v[3];
    temp_over = v[4]; temp_under = v[5]; sup_low = v[6]; tmode_timer = tm;
  endtask

  task automatic step(input logic [6:0] v, input logic tm);
    drive(v, tm);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string cause_tag(input logic [6:0] v, input logic tm);
    if (v[6])              return "R8";
    if (v[0] || v[1])      return "R2";
    if (v[2])              return "R4";
    if (v[3])              return "R5";
    if (v[4])              return "R6";
    if (v[5])              return "R7";
    return "R3";
  endfunction

  initial begin
    rst_n = 1'b0;
    drive(7'd0, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(ft_out, 1'b1, "R1", "fast after reset");
    check(clr_pulse, 1'b0, "R1", "no clear after reset");

    for (int tm = 0; tm < 2; tm++) begin
      for (int vi = 0; vi < 128; vi++) begin
        logic [6:0] v;
        logic win_ok, sok, rise, lat, ft1, ft2;
        string tg;
        v = 7'(vi);
        // empty latches: leave window, re-enter, settle
        step(7'b0000001, 1'(tm));
        step(7'd0, 1'(tm));
        step(7'd0, 1'(tm));
        win_ok = !(v[0] | v[1]);
        sok    = !v[6];
        ft1 = win_ok & sok & !v[2] & !(tm[0] & v[3]) & !(!tm[0] & (v[4] | v[5]));
        rise = !win_ok | !sok;
        lat  = sok & (v[2] | (tm[0] & v[3]) | (!tm[0] & v[4]));
        ft2  = rise ? 1'b1 : !lat;
        tg   = cause_tag(v, 1'(tm));
        step(v, 1'(tm));
        check(ft_out, ft1, tg, $sformatf("mode during v=%b tm=%0d", v, tm));
        check(clr_pulse, 1'b0, tg, $sformatf("no clear during v=%b tm=%0d", v, tm));
        step(7'd0, 1'(tm));
        check(ft_out, ft2, rise ? (v[6] ? "R8" : "R3") : tg,
              $sformatf("mode after v=%b tm=%0d", v, tm));
        check(clr_pulse, rise, v[6] ? "R8" : "R3", $sformatf("clear after v=%b tm=%0d", v, tm));
        step(7'd0, 1'(tm));
        check(ft_out, ft2, tg, $sformatf("persist after v=%b tm=%0d", v, tm));
        check(clr_pulse, 1'b0, "R3", $sformatf("clear one cycle v=%b tm=%0d", v, tm));
      end
    end

    // R9: set request on the same edge as window re-entry
    step(7'b0000010, 1'b1);
    step(7'b0000100, 1'b1);
    check(clr_pulse, 1'b1, "R9", "clear on re-entry with slope");
    check(ft_out, 1'b1, "R9", "clear beats slope set");
    step(7'd0, 1'b1);
    check(ft_out, 1'b1, "R9", "no latch after clear-vs-set");

    // R6: overtemp latch holds for several cycles after the flag falls
    step(7'b0010000, 1'b0);
    for (int k = 0; k < 5; k++) begin
      step(7'd0, 1'b0);
      check(ft_out, 1'b0, "R6", "overtemp latch persists");
    end
    // R8: supply low for a while clears it, recovery pulses once
    step(7'b1000000, 1'b0);
    step(7'b1000000, 1'b0);
    check(ft_out, 1'b0, "R8", "trickle while supply low");
    step(7'd0, 1'b0);
    check(clr_pulse, 1'b1, "R8", "clear on supply recovery");
    check(ft_out, 1'b1, "R8", "fast after supply recovery");

    // R7: long undertemp then recovery without clear
    for (int k = 0; k < 4; k++) begin
      step(7'b0100000, 1'b0);
      check(ft_out, 1'b0, "R7", "undertemp trickle");
    end
    step(7'd0, 1'b0);
    check(ft_out, 1'b1, "R7", "undertemp self-recovers");
    check(clr_pulse, 1'b0, "R7", "no clear on undertemp recovery");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule